// File: doc/BRIEF.md
# Low-Line Reset Sequencer

This block turns a digitized supply-good indication and a watchdog expiry request into the reset lines of a processor. It also blocks writes to a memory by gating that memory's active-low chip-enable. The supply-good level comes from an analog comparator outside the block, so it may change at any time. It is brought into the clock domain by a synchronizer. A backup-mode flag, already synchronous, marks the time when the system runs from its reserve source. The block treats that flag exactly like a supply failure.

Release from reset is timed in ticks of a selectable timebase. A tick is a one-cycle enable, and the hold length depends on which timebase is selected. One hold counter serves both kinds of release: recovery of the supply and a watchdog expiry. When a hold ends, the block raises a one-cycle strobe so the watchdog can restart its own period.

Top module: `lowline_reset_seq`

## Requirements
- R1: `resetN` is low in every cycle in which the internal supply-good level is false. That level is `supplyOkAsync`, taken through two synchronizer flops, ANDed with `!backupMode`. So a fall of `supplyOkAsync` drives `resetN` low two clock edges later.
- R2: After supply-good returns, `resetN` stays low for one cycle plus the time for the selected number of `tick` pulses. `resetN` rises in the cycle after the edge that takes the last counted tick. Cycles without a tick do not advance the hold.
- R3: `extClkMode` picks the hold length: 0 selects HOLD_INT_TICKS and 1 selects HOLD_EXT_TICKS. It is sampled once, at the edge where a hold starts.
- R4: A `wdTimeout` pulse seen at an edge while `resetN` is high starts a new hold of the same length, and `resetN` goes low in the next cycle.
- R5: A `wdTimeout` seen while a hold is running is ignored: it neither restarts nor extends the hold.
- R6: `reset` is the exact complement of `resetN` in every cycle.
- R7: `lowLineN` equals supply-good in the same cycle, with no hold delay on release.
- R8: `ceOutN` follows `ceInN` combinationally while supply-good is true, and is forced high while it is false.
- R9: While `backupMode` is high, `resetN` is low, `lowLineN` is low and `ceOutN` is high, whatever the level of `ceInN`.
- R10: `resetDoneStb` is high for exactly the one cycle in which `resetN` rises, and at no other time.
- R11: While `rstN` is low, `resetN` is low, `reset` is high, `lowLineN` is low, `ceOutN` is high and `resetDoneStb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low initialization |
| tick | input | 1 | One-cycle timebase enable that advances the hold |
| extClkMode | input | 1 | Hold length select: 0 internal, 1 external |
| supplyOkAsync | input | 1 | Supply comparator result, asynchronous |
| backupMode | input | 1 | Synchronous reserve-power flag |
| wdTimeout | input | 1 | Watchdog expiry request pulse |
| ceInN | input | 1 | Active-low chip-enable from the processor |
| resetN | output | 1 | Active-low processor reset |
| reset | output | 1 | Active-high processor reset |
| lowLineN | output | 1 | Low while supply is not good |
| ceOutN | output | 1 | Gated active-low chip-enable to memory |
| resetDoneStb | output | 1 | One-cycle strobe when reset releases |

## Verification
A watchdog request can fall in the same cycle as two other events, and each collision is provoked on purpose. In the first, a request lands in the cycle where supply-good drops, so the request must lose to the supply path. In the second, a request lands on the edge where the final hold tick is counted; it must be ignored because a hold is still running. In the third, a request lands in the cycle the end strobe is high, where it must start a fresh hold at once. The bench judges each collision by running a behavioural phase-and-countdown model and comparing all five outputs with it on every clock.

// File: rtl/lowline_reset_pkg.sv
package lowline_reset_pkg;
  typedef enum logic [1:0] {
    PH_DOWN = 2'd0,
    PH_HOLD = 2'd1,
    PH_RUN  = 2'd2
  } phaseT;

  typedef struct packed {
    logic load;
    logic count;
  } holdCmdT;
endpackage

// File: rtl/lowline_reset_dp.sv
module lowline_reset_dp
  import lowline_reset_pkg::*;
#(
  parameter int HOLD_INT_TICKS = 512,
  parameter int HOLD_EXT_TICKS = 512,
  parameter int SYNC_STAGES    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    extClkMode,
  input  logic    supplyOkAsync,
  input  logic    backupMode,
  input  logic    ceInN,
  input  holdCmdT cmd,
  output logic    supplyGood,
  output logic    holdDone,
  output logic    lowLineN,
  output logic    ceOutN
);
  localparam int MAX_HOLD = (HOLD_INT_TICKS > HOLD_EXT_TICKS) ? HOLD_INT_TICKS : HOLD_EXT_TICKS;
  localparam int CNT_W    = $clog2(MAX_HOLD + 1);
  localparam logic [CNT_W-1:0] LIM_INT = CNT_W'(HOLD_INT_TICKS - 1);
  localparam logic [CNT_W-1:0] LIM_EXT = CNT_W'(HOLD_EXT_TICKS - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       holdCnt;
  logic [CNT_W-1:0]       holdLast;

  // Synchronizer chain for the comparator level
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= supplyOkAsync;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= syncChain[i-1];
        end
      end
    end
  endgenerate

  assign supplyGood = syncChain[SYNC_STAGES-1] & ~backupMode;

  // Hold counter; the limit is captured when a hold starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= '0;
      holdLast <= LIM_INT;
    end else if (cmd.load) begin
      holdCnt  <= '0;
      holdLast <= extClkMode ? LIM_EXT : LIM_INT;
    end else if (cmd.count && tick) begin
      holdCnt  <= holdCnt + 1'b1;
    end
  end

  assign holdDone = cmd.count && tick && (holdCnt == holdLast);

  // Gating stays combinational after the synchronizer
  assign lowLineN = supplyGood;
  assign ceOutN   = ceInN | ~supplyGood;
endmodule

// File: rtl/lowline_reset_ctrl.sv
module lowline_reset_ctrl
  import lowline_reset_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    supplyGood,
  input  logic    wdTimeout,
  input  logic    holdDone,
  output holdCmdT cmd,
  output logic    resetN,
  output logic    resetDoneStb
);
  phaseT phase, phaseNext;
  logic  endFlag;

  always_comb begin
    phaseNext = phase;
    cmd       = '0;
    if (!supplyGood) begin
      phaseNext = PH_DOWN;
    end else begin
      unique case (phase)
        PH_DOWN: begin
          phaseNext = PH_HOLD;
          cmd.load  = 1'b1;
        end
        PH_HOLD: begin
          cmd.count = 1'b1;
          if (holdDone) phaseNext = PH_RUN;
        end
        PH_RUN: begin
          if (wdTimeout) begin
            phaseNext = PH_HOLD;
            cmd.load  = 1'b1;
          end
        end
        default: phaseNext = PH_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_DOWN;
      endFlag <= 1'b0;
    end else begin
      phase   <= phaseNext;
      endFlag <= supplyGood && (phase == PH_HOLD) && holdDone;
    end
  end

  assign resetN       = supplyGood && (phase == PH_RUN);
  assign resetDoneStb = endFlag && supplyGood;
endmodule

// File: rtl/lowline_reset_seq.sv
module lowline_reset_seq
  import lowline_reset_pkg::*;
#(
  parameter int HOLD_INT_TICKS = 512,
  parameter int HOLD_EXT_TICKS = 512
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic extClkMode,
  input  logic supplyOkAsync,
  input  logic backupMode,
  input  logic wdTimeout,
  input  logic ceInN,
  output logic resetN,
  output logic reset,
  output logic lowLineN,
  output logic ceOutN,
  output logic resetDoneStb
);
  holdCmdT cmd;
  logic    supplyGood;
  logic    holdDone;

  lowline_reset_dp #(
    .HOLD_INT_TICKS(HOLD_INT_TICKS),
    .HOLD_EXT_TICKS(HOLD_EXT_TICKS),
    .SYNC_STAGES   (2)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .extClkMode   (extClkMode),
    .supplyOkAsync(supplyOkAsync),
    .backupMode   (backupMode),
    .ceInN        (ceInN),
    .cmd          (cmd),
    .supplyGood   (supplyGood),
    .holdDone     (holdDone),
    .lowLineN     (lowLineN),
    .ceOutN       (ceOutN)
  );

  lowline_reset_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .supplyGood  (supplyGood),
    .wdTimeout   (wdTimeout),
    .holdDone    (holdDone),
    .cmd         (cmd),
    .resetN      (resetN),
    .resetDoneStb(resetDoneStb)
  );

  assign reset = ~resetN;
endmodule

// File: rtl/lowline_reset_seq_chk.sv
module lowline_reset_seq_chk (
  input logic clk,
  input logic rstN,
  input logic backupMode,
  input logic ceInN,
  input logic resetN,
  input logic reset,
  input logic lowLineN,
  input logic ceOutN,
  input logic resetDoneStb
);
  p_lowline_resets_r1: assert property (@(posedge clk) disable iff (!rstN)
    !lowLineN |-> !resetN);

  p_complement_r6: assert property (@(posedge clk) disable iff (!rstN)
    reset == !resetN);

  p_ce_forced_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lowLineN |-> ceOutN);

  p_ce_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    lowLineN |-> (ceOutN == ceInN));

  p_backup_state_r9: assert property (@(posedge clk) disable iff (!rstN)
    backupMode |-> (!resetN && !lowLineN && ceOutN));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    resetDoneStb |=> !resetDoneStb);

  p_strobe_at_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    resetDoneStb |-> (resetN && !$past(resetN)));

  p_release_strobed_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> resetDoneStb);
endmodule

bind lowline_reset_seq lowline_reset_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .backupMode  (backupMode),
  .ceInN       (ceInN),
  .resetN      (resetN),
  .reset       (reset),
  .lowLineN    (lowLineN),
  .ceOutN      (ceOutN),
  .resetDoneStb(resetDoneStb)
);

// File: tb/lowline_reset_seq_bench.sv
module lowline_reset_seq_bench;
  localparam int H_INT = 20;
  localparam int H_EXT = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic extClkMode = 1'b0;
  logic supplyOkAsync = 1'b0;
  logic backupMode = 1'b0;
  logic wdTimeout = 1'b0;
  logic ceInN = 1'b1;
  logic resetN, reset, lowLineN, ceOutN, resetDoneStb;

  int checks = 0;
  int fails = 0;
  int tickPeriod = 1;
  int tickCnt = 0;
  string scen = "R11";

  // behavioural model state
  bit s1 = 0, s2 = 0;
  int ph = 0;         // 0 down, 1 hold, 2 run
  int rem = 0;
  bit endM = 0;

  always #10 clk = ~clk;

  lowline_reset_seq #(.HOLD_INT_TICKS(H_INT), .HOLD_EXT_TICKS(H_EXT)) u_lowline_reset_seq (
    .clk(clk), .rstN(rstN), .tick(tick), .extClkMode(extClkMode),
    .supplyOkAsync(supplyOkAsync), .backupMode(backupMode), .wdTimeout(wdTimeout),
    .ceInN(ceInN), .resetN(resetN), .reset(reset), .lowLineN(lowLineN),
    .ceOutN(ceOutN), .resetDoneStb(resetDoneStb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, scen, $time, act, exp);
    end
  endtask

  // model advance at each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 = 0; s2 = 0; ph = 0; rem = 0; endM = 0;
    end else begin
      bit g;
      g = s2 && !backupMode;
      endM = 0;
      if (!g) ph = 0;
      else if (ph == 0) begin
        ph = 1; rem = extClkMode ? H_EXT : H_INT;
      end else if (ph == 1) begin
        if (tick) begin
          rem--;
          if (rem == 0) begin ph = 2; endM = 1; end
        end
      end else if (wdTimeout) begin
        ph = 1; rem = extClkMode ? H_EXT : H_INT;
      end
      s2 = s1; s1 = supplyOkAsync;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    bit g, eRn, eCe, eStb;
    g    = s2 && !backupMode;
    eRn  = g && (ph == 2);
    eCe  = ceInN || !g;
    eStb = endM && g;
    chk(resetN === eRn, "R1 resetN", resetN, eRn);
    chk(reset === !eRn, "R6 reset", reset, !eRn);
    chk(lowLineN === g, "R7 lowLineN", lowLineN, g);
    chk(ceOutN === eCe, "R8 ceOutN", ceOutN, eCe);
    chk(resetDoneStb === eStb, "R10 resetDoneStb", resetDoneStb, eStb);
  end

  // tick generator
  always @(negedge clk) begin
    #1;
    tickCnt++;
    tick <= (tickPeriod == 1) || (tickCnt % tickPeriod == 0);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #2;
  endtask

  task automatic wdPulse();
    wdTimeout = 1'b1; cyc(1); wdTimeout = 1'b0;
  endtask

  // wait in negedge steps until the reset output reaches a level
  task automatic waitReset(input bit lvl, input int lim);
    for (int i = 0; i < lim && resetN !== lvl; i++) cyc(1);
  endtask

  initial begin
    // R11: initialization state
    cyc(3);
    chk(resetN === 1'b0, "R11 resetN in init", resetN, 0);
    chk(reset === 1'b1, "R11 reset in init", reset, 1);
    chk(lowLineN === 1'b0, "R11 lowLineN in init", lowLineN, 0);
    chk(ceOutN === 1'b1, "R11 ceOutN in init", ceOutN, 1);
    chk(resetDoneStb === 1'b0, "R11 strobe in init", resetDoneStb, 0);
    rstN = 1'b1;

    // R2: power-up hold on the internal length, tick every cycle
    scen = "R2 power-up";
    supplyOkAsync = 1'b1; ceInN = 1'b0;
    cyc(H_INT + 6);
    chk(resetN === 1'b1, "R2 released after hold", resetN, 1);
    ceInN = 1'b1; cyc(2); ceInN = 1'b0; cyc(2);

    // R4: watchdog request while running
    scen = "R4 watchdog pulse";
    wdPulse();
    chk(resetN === 1'b0, "R4 reset after request", resetN, 0);
    cyc(5);
    // R5: request during hold is ignored
    scen = "R5 request in hold";
    wdPulse();
    cyc(H_INT);
    // collision: request on the strobe cycle restarts a hold
    scen = "R4 request on strobe";
    waitReset(1'b1, 100);
    wdTimeout = 1'b1; cyc(1); wdTimeout = 1'b0;
    waitReset(1'b1, 100);
    cyc(3);

    // R3: external length, sparse ticks, supply dip with request in same cycle
    scen = "R3 external length";
    extClkMode = 1'b1; tickPeriod = 3;
    supplyOkAsync = 1'b0; cyc(2);
    wdTimeout = 1'b1; cyc(1); wdTimeout = 1'b0;
    ceInN = 1'b0; cyc(3); ceInN = 1'b1; cyc(1);
    supplyOkAsync = 1'b1;
    cyc(3 * H_EXT + 8);
    chk(resetN === 1'b1, "R3 released after external hold", resetN, 1);

    // R2: supply glitch inside a hold restarts it
    scen = "R2 glitch in hold";
    extClkMode = 1'b0; tickPeriod = 2;
    wdPulse(); cyc(6);
    supplyOkAsync = 1'b0; cyc(1); supplyOkAsync = 1'b1;
    cyc(2 * H_INT + 10);

    // collision: request on the edge of the final tick
    scen = "R5 request on last tick";
    tickPeriod = 1;
    wdPulse();
    cyc(H_INT - 1);
    wdTimeout = 1'b1; cyc(1); wdTimeout = 1'b0;
    cyc(6);

    // R9: backup mode
    scen = "R9 backup";
    backupMode = 1'b1;
    for (int i = 0; i < 8; i++) begin ceInN = i[0]; cyc(1); end
    chk(ceOutN === 1'b1 && resetN === 1'b0 && lowLineN === 1'b0, "R9 backup outputs",
        {ceOutN, resetN, lowLineN}, 3'b100);
    backupMode = 1'b0; ceInN = 1'b0;
    cyc(H_INT + 6);
    chk(resetN === 1'b1, "R9 release after backup", resetN, 1);
    cyc(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired [%s]", scen);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule